// File: doc/BRIEF.md
# Parallel PRBS-15 Word Checker

This block checks a pseudo-random bit stream of period 2^15-1. The stream arrives ten bits at a time, qualified by a valid strobe, for example from a bit packer that follows a clock-and-data recovery stage. The checker needs no seed from outside. It keeps the fifteen most recently received bits and uses them to predict every bit of the next word. Any word whose bits differ from the prediction is flagged.

Two indications come out. A real-time flag marks each checked word that held a mismatch. A sticky flag latches the first error and holds it until a clear strobe re-arms it. The checker resynchronises by itself after corruption, because its predictions come only from received bits. Straight after reset, bits that lack a full fifteen-bit history are never judged.

Top module: `prbs_word_checker`

## Requirements
- R1: Every checked bit must equal the XOR of the received bits 14 and 15 positions earlier in the stream (polynomial x^15 + x^14 + 1). A stream that obeys this rule raises no error.
- R2: `word_in` carries ten stream bits per word. Bit 0 is the earliest received bit and bit 9 is the latest, and bit order within a word counts in the prediction.
- R3: A word is consumed only in a cycle with `word_vld` high. In other cycles `word_in` is ignored, the history stays as it is, and `err_rt` is low in the following cycle.
- R4: `err_rt` is high in the cycle after an accepted word that holds at least one mismatching bit, and low after an accepted word with none.
- R5: `err_sticky` goes high in the same cycle as `err_rt` for any detected error. It then stays high for as long as `err_clr` is low.
- R6: `err_clr` high in a cycle makes `err_sticky` low in the next cycle, unless that same cycle accepts a word with an error, in which case the flag stays set. After a clear, the flag waits for the next error.
- R7: After reset, a bit among the first fifteen accepted bits is never reported as an error. The first word is therefore never flagged, and bits 5 to 9 of the second word are checked.
- R8: After any corruption, the checker reports no error once fifteen consecutive correct bits have been accepted.
- R9: The asynchronous active-low reset clears both flags and the history at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_vld | input | 1 | Word qualifier; `word_in` is consumed when high |
| word_in | input | 10 | Stream bits; bit 0 is the earliest |
| err_clr | input | 1 | Re-arm strobe for the sticky flag |
| err_rt | output | 1 | Mismatch in the word accepted on the previous cycle |
| err_sticky | output | 1 | Latched error indication |

## Verification
The case that is hardest to reach from the ports is a clear that arrives in the same cycle as an erroneous word. Both inputs must line up exactly, and the error must come from corruption, not from the start-up period in which bits are masked. The bench reaches it on purpose: it flips one bit of a word and drives the clear in that same cycle. A long random phase then mixes gaps, single-bit flips and clears, and a bit-serial queue model of the recurrence predicts the outcome every cycle, including the two or three words that a single flip disturbs. Reseeding after a reset mid-stream, starting from an arbitrary fifteen-bit state, exercises the start-up masking.

// File: rtl/prbs15_pkg.sv
package prbs15_pkg;
    // Default geometry: 10-bit words, 15-bit history, near tap 14 (far tap = history length)
    localparam int DEF_WORD_W   = 10;
    localparam int DEF_HIST_W   = 15;
    localparam int DEF_TAP_NEAR = 14;
endpackage

// File: rtl/prbs_predict.sv
module prbs_predict #(
    parameter int WORD_W   = 10,
    parameter int HIST_W   = 15,
    parameter int TAP_NEAR = 14
) (
    input  logic [HIST_W-1:0] hist,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] expect_word,
    output logic [HIST_W-1:0] hist_next
);
    // hist[HIST_W-1] is the newest received bit. Both taps reach back at least
    // WORD_W bits, so every predicted bit depends on history alone.
    localparam int NEAR_OFS = HIST_W - TAP_NEAR;

    logic [WORD_W+HIST_W-1:0] stream;
    assign stream = {word, hist};

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        assign expect_word[i] = hist[i + NEAR_OFS] ^ hist[i];
    end

    assign hist_next = stream[WORD_W+HIST_W-1:WORD_W];
endmodule

// File: rtl/prbs_fill.sv
module prbs_fill #(
    parameter int WORD_W = 10,
    parameter int HIST_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [WORD_W-1:0] check_mask
);
    localparam int FILL_W = $clog2(HIST_W + WORD_W + 1);

    typedef struct packed {
        logic [FILL_W-1:0] fill;
    } fill_st_t;

    fill_st_t st_d, st_q;

    always_comb begin
        int sum;
        st_d = st_q;
        sum  = int'(st_q.fill) + WORD_W;
        if (advance) begin
            st_d.fill = (sum >= HIST_W) ? FILL_W'(HIST_W) : FILL_W'(sum);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // bit i may be judged only when its two taps are real received bits
    for (genvar i = 0; i < WORD_W; i++) begin : g_mask
        assign check_mask[i] = (int'(st_q.fill) + i) >= HIST_W;
    end

    AST_FILL_NEVER_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.fill >= $past(st_q.fill)); // R7
    AST_FILL_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.fill) <= HIST_W); // R7
endmodule

// File: rtl/prbs_flags.sv
module prbs_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic word_vld,
    input  logic word_err,
    input  logic err_clr,
    output logic err_rt,
    output logic err_sticky
);
    typedef struct packed {
        logic rt;
        logic sticky;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        logic hit;
        hit       = word_vld && word_err;
        st_d.rt   = hit;
        // a fresh error outranks a simultaneous clear
        if (hit)          st_d.sticky = 1'b1;
        else if (err_clr) st_d.sticky = 1'b0;
        else              st_d.sticky = st_q.sticky;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_rt     = st_q.rt;
    assign err_sticky = st_q.sticky;

    AST_RT_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> !err_rt); // R3
    AST_RT_IMPLIES_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_rt |-> err_sticky); // R5
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky && !err_clr |=> err_sticky); // R5
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !(word_vld && word_err) |=> !err_sticky); // R6
endmodule

// File: rtl/prbs_word_checker.sv
module prbs_word_checker
    import prbs15_pkg::*;
#(
    parameter int WORD_W   = DEF_WORD_W,
    parameter int HIST_W   = DEF_HIST_W,
    parameter int TAP_NEAR = DEF_TAP_NEAR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_in,
    input  logic              err_clr,
    output logic              err_rt,
    output logic              err_sticky
);
    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } chk_st_t;

    chk_st_t           st_d, st_q;
    logic [WORD_W-1:0] expect_word;
    logic [HIST_W-1:0] hist_next;
    logic [WORD_W-1:0] check_mask;
    logic              word_err;

    prbs_predict #(
        .WORD_W  (WORD_W),
        .HIST_W  (HIST_W),
        .TAP_NEAR(TAP_NEAR)
    ) u_predict (
        .hist       (st_q.hist),
        .word       (word_in),
        .expect_word(expect_word),
        .hist_next  (hist_next)
    );

    prbs_fill #(
        .WORD_W(WORD_W),
        .HIST_W(HIST_W)
    ) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (word_vld),
        .check_mask(check_mask)
    );

    assign word_err = |((word_in ^ expect_word) & check_mask);

    always_comb begin
        st_d = st_q;
        if (word_vld) st_d.hist = hist_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    prbs_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_vld  (word_vld),
        .word_err  (word_err),
        .err_clr   (err_clr),
        .err_rt    (err_rt),
        .err_sticky(err_sticky)
    );

    AST_HIST_STILL_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> $stable(st_q.hist)); // R3
    AST_FIRST_WORD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld && check_mask == '0 |=> !err_rt); // R7
endmodule

// File: tb/prbs_word_checker_tb.sv
`timescale 1ns/1ps
module prbs_word_checker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       word_vld = 1'b0;
    logic [9:0] word_in = '0;
    logic       err_clr = 1'b0;
    logic       err_rt, err_sticky;

    always #2.5 clk = ~clk;

    prbs_word_checker u_dut (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_in),
        .err_clr(err_clr), .err_rt(err_rt), .err_sticky(err_sticky)
    );

    int    n_run = 0, n_fail = 0;
    bit    done = 0;
    bit    q[$];
    bit    exp_rt = 0, exp_st = 0;
    logic [14:0] g;
    string tag = "R9";

    task automatic check(string what, logic act, logic expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, expv, $time);
        end
    endtask

    // bit-serial reference: each bit after the 15th equals bits 14 and 15 back XORed
    task automatic model(bit vld, logic [9:0] w, bit clr);
        bit err = 0;
        if (vld) begin
            for (int i = 0; i < 10; i++) begin
                if (q.size() >= 15 && (w[i] != (q[q.size()-14] ^ q[q.size()-15]))) err = 1;
                q.push_back(w[i]);
                if (q.size() > 15) void'(q.pop_front());
            end
        end
        exp_rt = vld && err;
        if (vld && err) exp_st = 1;
        else if (clr)   exp_st = 0;
    endtask

    function automatic logic [9:0] gen_word();
        logic [9:0] w;
        for (int i = 0; i < 10; i++) begin
            w[i] = g[13] ^ g[14];
            g = {g[13:0], w[i]};
        end
        return w;
    endfunction

    task automatic cycle(bit vld, logic [9:0] w, bit clr);
        @(negedge clk);
        check("err_rt", err_rt, exp_rt);
        check("err_sticky", err_sticky, exp_st);
        word_vld = vld; word_in = w; err_clr = clr;
        model(vld, w, clr);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; word_vld = 0; err_clr = 0;
        q.delete(); exp_rt = 0; exp_st = 0;
        #1;
        tag = "R9 reset";
        check("err_rt", err_rt, 1'b0);
        check("err_sticky", err_sticky, 1'b0);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        do_reset();

        tag = "R1 R2 R7 clean stream";
        g = 15'h5A3C;
        for (int k = 0; k < 30; k++) cycle(1, gen_word(), 0);

        tag = "R3 gaps ignored";
        for (int k = 0; k < 60; k++) begin
            if ($urandom_range(0, 2) == 0) cycle(0, 10'($urandom), 0);
            else                           cycle(1, gen_word(), 0);
        end

        tag = "R4 R5 R8 single flip";
        cycle(1, gen_word() ^ 10'h008, 0);
        for (int k = 0; k < 6; k++) cycle(1, gen_word(), 0);

        tag = "R6 clear idle";
        cycle(0, '0, 1);
        for (int k = 0; k < 4; k++) cycle(1, gen_word(), 0);

        tag = "R6 clear with error";
        cycle(1, gen_word() ^ 10'h200, 1);
        for (int k = 0; k < 5; k++) cycle(1, gen_word(), 0);
        cycle(1, gen_word(), 1);
        cycle(1, gen_word(), 0);

        tag = "R2 reversed word";
        begin
            logic [9:0] w;
            w = gen_word();
            cycle(1, {<<{w}}, 0);
        end
        for (int k = 0; k < 5; k++) cycle(1, gen_word(), 1);

        do_reset();
        tag = "R7 R1 reseed";
        g = 15'h0001;
        for (int k = 0; k < 25; k++) cycle(1, gen_word(), 0);

        tag = "R3 R4 R5 R6 R8 random";
        for (int k = 0; k < 1500; k++) begin
            bit vld, clr;
            logic [9:0] w;
            vld = $urandom_range(0, 3) != 0;
            clr = $urandom_range(0, 29) == 0;
            if (vld) begin
                w = gen_word();
                if ($urandom_range(0, 39) == 0) w[$urandom_range(0, 9)] ^= 1'b1;
            end else w = 10'($urandom);
            cycle(vld, w, clr);
        end
        cycle(0, '0, 0);
        cycle(0, '0, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired tag=%s actual=running expected=done", tag);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule